// File: doc/BRIEF.md
# DRAM Controller Register Shim with Row-Mirror Aliasing

This block stands in for the configuration face of a DDR memory controller. It holds three banks of 32-bit registers (a common bank, a controller bank and a PHY bank) behind a simple valid/ready slave port. A PHY-initialisation write reports completion at once. No DRAM commands, refresh or PHY training are produced.

The second half of the block is an address-aliasing unit on the memory path. Boot firmware sizes memory by programming the widest row geometry and writing a marker one row boundary past the start of memory. It then checks whether the marker shows up at offset zero. When the programmed row count is larger than the fitted memory, the block redirects a 4 KiB window placed one real row boundary past the base onto the first 4 KiB of memory. The probe then sees the wrap-around a real part would show.

The fitted size is a parameter in MiB. Only 256, 512, 1024 and 2048 are accepted, and any other value stops elaboration.

Top module: `dram_shim_top`

## Requirements
- R1: After reset every register in every bank reads as zero and no memory address is redirected: `mem_mirror_hit` stays low and `mem_addr_out` equals `mem_addr_in`.
- R2: `reg_ready` is always high. A read accepted in cycle T raises `reg_rvalid` in T+1, with the stored word on `reg_rdata`. A write accepted in cycle T is visible to a read accepted in T+1 or later.
- R3: Byte address `reg_addr` selects a word in the bank chosen by `reg_win`, which is encoded 0 = common, 1 = controller, 2 = PHY, 3 = unmapped. The last valid word offsets are 0x804 (common), 0x88C (controller) and 0x004 (PHY). A read beyond the last offset, or a read of the unmapped bank, returns zero. A write there changes nothing.
- R4: Only whole-word accesses count: `reg_be` must be 4'hF and `reg_addr[1:0]` must be zero. Any other write is dropped and any other read returns zero.
- R5: Any whole-word write to controller offset 0x00 stores its data there. It also sets bit 0 of controller offset 0x10 and bit 0 of controller offset 0x18, and leaves the other bits of those two words as they were.
- R6: A whole-word write to common offset 0x00 is decoded as geometry: row bits = word[7:4] + 1, bank bits = word[2] + 2, page bytes = 2^(word[11:8] + 3). If row bits differ from log2(MEM_MIB) + 3, the mirror is switched on at BASE_ADDR + 2^(log2(MEM_MIB) + 3 + bank bits) × page bytes. That address wraps modulo 2^ADDR_W.
- R7: When row bits equal log2(MEM_MIB) + 3, that geometry write switches the mirror off. No write to any other offset or bank changes the mirror state.
- R8: While the mirror is on, an address inside the 4 KiB window starting at the mirror base gives `mem_mirror_hit` = 1 and `mem_addr_out` = BASE_ADDR + (address − mirror base). Every other address passes through unchanged with the hit flag low. A geometry write accepted in cycle T takes effect in T+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_win | input | 2 | Bank select: 0 common, 1 controller, 2 PHY, 3 unmapped |
| reg_addr | input | 12 | Byte offset inside the bank |
| reg_be | input | 4 | Byte enables; only 4'hF is accepted |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read |
| reg_rdata | output | 32 | Read data |
| mem_addr_in | input | ADDR_W | Byte address from the memory path |
| mem_addr_out | output | ADDR_W | Address after mirror redirection |
| mem_mirror_hit | output | 1 | High when `mem_addr_in` falls in the mirror window |

## Verification
Register reads are due exactly one clock after the accepting edge. The bench drives each request on a falling edge, deasserts it on the next falling edge, and samples `reg_rvalid` and `reg_rdata` just after that second edge. Mirror redirection is combinational from a mirror state that loads on the accepting edge of a geometry write. The behavioural model therefore updates its own mirror state at the falling edge that follows the write. Every falling edge, a few time units into the low phase, compares `mem_addr_out` and `mem_mirror_hit` against the model, so the first cycle of a new mirror setting is always checked.

// File: rtl/dram_shim_pkg.sv
package dram_shim_pkg;

  localparam int REG_AW  = 12;
  localparam int IDX_W   = REG_AW - 2;
  localparam int DATA_W  = 32;
  localparam int NUM_WIN = 3;

  typedef enum logic [1:0] {
    WIN_COM  = 2'd0,
    WIN_CTL  = 2'd1,
    WIN_PHY  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  // word indices with side effects
  localparam int GEOM_IDX      = 0;  // common bank: geometry word
  localparam int INIT_IDX      = 0;  // controller bank: PHY init trigger
  localparam int DONE_FLAG_IDX = 4;  // controller bank: init-done flag word
  localparam int ACT_FLAG_IDX  = 6;  // controller bank: active flag word

  function automatic int win_last_off(input int w);
    case (w)
      0:       return 'h804;
      1:       return 'h88C;
      default: return 'h004;
    endcase
  endfunction

  function automatic bit mib_legal_f(input int mib);
    return (mib == 256) || (mib == 512) || (mib == 1024) || (mib == 2048);
  endfunction

  function automatic logic [4:0] row_bits_f(input logic [31:0] cw);
    return {1'b0, cw[7:4]} + 5'd1;
  endfunction

  function automatic logic [1:0] bank_bits_f(input logic [31:0] cw);
    return {1'b0, cw[2]} + 2'd2;
  endfunction

  function automatic logic [4:0] page_log2_f(input logic [31:0] cw);
    return {1'b0, cw[11:8]} + 5'd3;
  endfunction

  function automatic logic geom_matches_f(input logic [4:0] rb, input int mib_log2);
    return (rb >= 5'd3) && ((int'(rb) - 3) == mib_log2);
  endfunction

  function automatic logic [5:0] mirror_exp_f(input int mib_log2, input logic [1:0] bb,
                                              input logic [4:0] pl);
    return 6'(mib_log2 + 3) + {4'b0, bb} + {1'b0, pl};
  endfunction

  function automatic logic [63:0] mirror_off_f(input logic [5:0] e);
    return 64'd1 << e;
  endfunction

endpackage

// File: rtl/dram_regwin.sv
module dram_regwin
  import dram_shim_pkg::*;
#(
  parameter int LAST_OFF  = 'h804,
  parameter bit HAS_FLAGS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_set,
  output logic [DATA_W-1:0] rd_word
);

  localparam int WORDS = LAST_OFF / 4 + 1;
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [DATA_W-1:0] words [WORDS];
  logic              in_range;
  logic [SEL_W-1:0]  sel;

  assign in_range = (idx < IDX_W'(WORDS));
  assign sel      = idx[SEL_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam bit SETS = HAS_FLAGS && ((w == DONE_FLAG_IDX) || (w == ACT_FLAG_IDX));
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q    <= '0;
      else if (wr_en && idx == IDX_W'(w)) q   <= wdata;
      else if (SETS && flag_set)         q[0] <= 1'b1;
    end
    assign words[w] = q;
  end

  if (!HAS_FLAGS) begin : g_noflag
    logic unused_flag;
    assign unused_flag = flag_set;
  end

  assign rd_word = in_range ? words[sel] : '0;

endmodule

// File: rtl/dram_row_mirror.sv
module dram_row_mirror
  import dram_shim_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int              MIB_LOG2  = 8,
  parameter int              WIN_LOG2  = 12,
  parameter int              PARK_OFF  = 1 << 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_load,
  input  logic [DATA_W-1:0] cw_value,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              hit
);

  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [4:0]        rb;
  logic [5:0]        exp_w;
  logic [63:0]       off_full;
  logic [ADDR_W-1:0] base_next;
  logic              geom_match;

  assign rb         = row_bits_f(cw_value);
  assign geom_match = geom_matches_f(rb, MIB_LOG2);
  assign exp_w      = mirror_exp_f(MIB_LOG2, bank_bits_f(cw_value), page_log2_f(cw_value));
  assign off_full   = mirror_off_f(exp_w);
  assign base_next  = ADDR_W'(64'(BASE_ADDR) + off_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= BASE_ADDR + ADDR_W'(PARK_OFF);
    end else if (cw_load) begin
      if (geom_match) begin
        en_q <= 1'b0;
      end else begin
        en_q   <= 1'b1;
        base_q <= base_next;
      end
    end
  end

  assign hit      = en_q && (((addr_in ^ base_q) >> WIN_LOG2) == '0);
  assign addr_out = hit ? {BASE_ADDR[ADDR_W-1:WIN_LOG2], addr_in[WIN_LOG2-1:0]} : addr_in;

endmodule

// File: rtl/dram_shim_top.sv
module dram_shim_top
  import dram_shim_pkg::*;
#(
  parameter int                MEM_MIB   = 256,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  parameter int                WIN_LOG2  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [1:0]        reg_win,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] mem_addr_in,
  output logic [ADDR_W-1:0] mem_addr_out,
  output logic              mem_mirror_hit
);

  localparam int MIB_LOG2 = $clog2(MEM_MIB);

  if (!mib_legal_f(MEM_MIB)) begin : g_bad_size
    $error("MEM_MIB must be 256, 512, 1024 or 2048");
  end
  if (BASE_ADDR[WIN_LOG2-1:0] != '0) begin : g_bad_base
    $error("BASE_ADDR must be aligned to the mirror window");
  end

  // named access events
  logic               word_ok;
  logic               acc_rd;
  logic               acc_wr_ok;
  logic [IDX_W-1:0]   acc_idx;
  logic [NUM_WIN-1:0] win_we;
  logic               ctl_word_wr;
  logic               phy_init_wr;
  logic [DATA_W-1:0]  win_word [NUM_WIN];
  logic [DATA_W-1:0]  sel_word;

  assign reg_ready = 1'b1;
  assign word_ok   = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
  assign acc_rd    = reg_valid && !reg_write;
  assign acc_wr_ok = reg_valid && reg_write && word_ok;
  assign acc_idx   = reg_addr[REG_AW-1:2];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_we[g] = acc_wr_ok && (reg_win == 2'(g));
    dram_regwin #(
      .LAST_OFF  (win_last_off(g)),
      .HAS_FLAGS (g == int'(WIN_CTL))
    ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (win_we[g]),
      .idx      (acc_idx),
      .wdata    (reg_wdata),
      .flag_set (phy_init_wr),
      .rd_word  (win_word[g])
    );
  end

  assign ctl_word_wr = win_we[WIN_COM] && (acc_idx == IDX_W'(GEOM_IDX));
  assign phy_init_wr = win_we[WIN_CTL] && (acc_idx == IDX_W'(INIT_IDX));

  always_comb begin
    sel_word = '0;
    if (word_ok && reg_win != WIN_NONE) sel_word = win_word[reg_win];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= acc_rd;
      if (acc_rd) reg_rdata <= sel_word;
    end
  end

  dram_row_mirror #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .MIB_LOG2  (MIB_LOG2),
    .WIN_LOG2  (WIN_LOG2)
  ) u_mirror (
    .clk      (clk),
    .rst_n    (rst_n),
    .cw_load  (ctl_word_wr),
    .cw_value (reg_wdata),
    .addr_in  (mem_addr_in),
    .addr_out (mem_addr_out),
    .hit      (mem_mirror_hit)
  );

endmodule

// File: rtl/dram_shim_chk.sv
module dram_shim_chk #(
  parameter int                MEM_MIB   = 256,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  parameter int                WIN_LOG2  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [1:0]        reg_win,
  input logic [3:0]        reg_be,
  input logic [31:0]       reg_wdata,
  input logic              reg_rvalid,
  input logic [31:0]       reg_rdata,
  input logic [ADDR_W-1:0] mem_addr_in,
  input logic [ADDR_W-1:0] mem_addr_out,
  input logic              mem_mirror_hit,
  input logic              ctl_word_wr
);

  localparam logic [3:0] MATCH_FIELD = 4'($clog2(MEM_MIB) + 2);

  logic seen_load;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_load <= 1'b0;
    else if (ctl_word_wr) seen_load <= 1'b1;
  end

  assert_no_hit_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load |-> !mem_mirror_hit);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> reg_rvalid);

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_win == 2'd3) |=> (reg_rdata == '0));

  assert_partial_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_be != 4'hF) |=> (reg_rdata == '0));

  assert_match_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word_wr && reg_wdata[7:4] == MATCH_FIELD) |=> !mem_mirror_hit);

  assert_alias_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_mirror_hit |-> (mem_addr_out[WIN_LOG2-1:0] == mem_addr_in[WIN_LOG2-1:0] &&
                        mem_addr_out[ADDR_W-1:WIN_LOG2] == BASE_ADDR[ADDR_W-1:WIN_LOG2]));

  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_mirror_hit |-> (mem_addr_out == mem_addr_in));

endmodule

bind dram_shim_top dram_shim_chk #(
  .MEM_MIB   (MEM_MIB),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .WIN_LOG2  (WIN_LOG2)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_valid      (reg_valid),
  .reg_write      (reg_write),
  .reg_win        (reg_win),
  .reg_be         (reg_be),
  .reg_wdata      (reg_wdata),
  .reg_rvalid     (reg_rvalid),
  .reg_rdata      (reg_rdata),
  .mem_addr_in    (mem_addr_in),
  .mem_addr_out   (mem_addr_out),
  .mem_mirror_hit (mem_mirror_hit),
  .ctl_word_wr    (ctl_word_wr)
);

// File: tb/sim_dram_shim_top.sv
module sim_dram_shim_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          MIB        = 256;
  localparam logic [31:0] BASE       = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_ready;
  logic        reg_write = 1'b0;
  logic [1:0]  reg_win = 2'd0;
  logic [11:0] reg_addr = '0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic [31:0] mem_addr_in = '0;
  logic [31:0] mem_addr_out;
  logic        mem_mirror_hit;

  dram_shim_top #(.MEM_MIB(MIB), .ADDR_W(32), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_win(reg_win), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .mem_addr_in(mem_addr_in), .mem_addr_out(mem_addr_out), .mem_mirror_hit(mem_mirror_hit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // behavioural reference model
  bit [31:0] m_bank [3][int];
  bit        m_en   = 1'b0;
  bit [31:0] m_base = BASE + 32'h0010_0000;

  function automatic int limit_of(input int w);
    if (w == 0) return 'h804;
    if (w == 1) return 'h88C;
    return 'h004;
  endfunction

  function automatic bit legal(input int w, input int addr, input logic [3:0] be);
    return (be == 4'hF) && (addr % 4 == 0) && (w < 3) && (addr <= limit_of(w));
  endfunction

  function automatic bit [31:0] model_read(input int w, input int addr, input logic [3:0] be);
    if (!legal(w, addr, be)) return 32'h0;
    if (!m_bank[w].exists(addr)) return 32'h0;
    return m_bank[w][addr];
  endfunction

  task automatic model_geom(input bit [31:0] d);
    int rows, banks, pexp, actual, a;
    longint unsigned off;
    rows  = int'(d[7:4]) + 1;
    banks = int'(d[2]) + 2;
    pexp  = int'(d[11:8]) + 3;
    a = 0;
    while ((1 << a) < MIB) a++;
    actual = a + 3;
    if (rows >= 3 && MIB == (1 << (rows - 3))) begin
      m_en = 1'b0;
    end else begin
      off = 1;
      for (int i = 0; i < actual + banks; i++) off = off * 2;
      for (int i = 0; i < pexp; i++) off = off * 2;
      m_base = BASE + off[31:0];
      m_en   = 1'b1;
    end
  endtask

  task automatic model_write(input int w, input int addr, input logic [3:0] be, input bit [31:0] d);
    if (!legal(w, addr, be)) return;
    if (w == 1 && addr == 0) begin
      m_bank[1]['h10] = model_read(1, 'h10, 4'hF) | 32'h1;
      m_bank[1]['h18] = model_read(1, 'h18, 4'hF) | 32'h1;
    end
    m_bank[w][addr] = d;
    if (w == 0 && addr == 0) model_geom(d);
  endtask

  task automatic model_map(input bit [31:0] a, output bit [31:0] o, output bit h);
    longint unsigned la, lb;
    la = a;
    lb = m_base;
    h  = m_en && la >= lb && la < lb + 4096;
    o  = h ? BASE + (a - m_base) : a;
  endtask

  task automatic check(input bit ok, input string req, input bit [31:0] act, input bit [31:0] exp,
                       input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // every cycle: memory path against model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [31:0] eo;
      bit        eh;
      #3;
      model_map(mem_addr_in, eo, eh);
      check(mem_addr_out == eo, "R8", mem_addr_out, eo, "per-cycle remap");
      check(mem_mirror_hit == eh, "R8", {31'b0, mem_mirror_hit}, {31'b0, eh}, "per-cycle hit");
    end
  end

  task automatic wr(input int w, input int addr, input logic [3:0] be, input bit [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_win = 2'(w);
    reg_addr = 12'(addr); reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    model_write(w, addr, be, d);
  endtask

  task automatic rd(input int w, input int addr, input logic [3:0] be, input string req);
    bit [31:0] e;
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_win = 2'(w);
    reg_addr = 12'(addr); reg_be = be;
    e = model_read(w, addr, be);
    @(negedge clk);
    reg_valid = 1'b0;
    #1;
    check(reg_rvalid == 1'b1, req, {31'b0, reg_rvalid}, 32'h1, "rvalid");
    check(reg_rdata == e, req, reg_rdata, e, $sformatf("read bank %0d off 0x%03h", w, addr));
  endtask

  task automatic probe(input bit [31:0] a, input bit exp_hit, input bit [31:0] exp_out,
                       input string req);
    @(negedge clk);
    mem_addr_in = a;
    #2;
    check(mem_mirror_hit == exp_hit, req, {31'b0, mem_mirror_hit}, {31'b0, exp_hit}, "probe hit");
    check(mem_addr_out == exp_out, req, mem_addr_out, exp_out, "probe addr");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    check(reg_ready == 1'b1, "R2", {31'b0, reg_ready}, 32'h1, "ready");
    rd(0, 'h000, 4'hF, "R1");
    rd(1, 'h010, 4'hF, "R1");
    rd(2, 'h004, 4'hF, "R1");
    probe(32'h4010_0010, 1'b0, 32'h4010_0010, "R1");

    // R2: write then read back
    wr(0, 'h100, 4'hF, 32'hDEAD_BEEF);
    rd(0, 'h100, 4'hF, "R2");
    wr(2, 'h004, 4'hF, 32'h1234_5678);
    rd(2, 'h004, 4'hF, "R2");

    // R3: bounds and unmapped bank
    wr(1, 'h88C, 4'hF, 32'hCAFE_0001);
    rd(1, 'h88C, 4'hF, "R3");
    wr(0, 'h808, 4'hF, 32'h5555_AAAA);
    rd(0, 'h808, 4'hF, "R3");
    wr(2, 'h008, 4'hF, 32'h7777_7777);
    rd(2, 'h008, 4'hF, "R3");
    wr(3, 'h000, 4'hF, 32'h9999_9999);
    rd(3, 'h000, 4'hF, "R3");

    // R4: partial and misaligned
    wr(0, 'h100, 4'h3, 32'h0000_1234);
    rd(0, 'h100, 4'hF, "R4");
    rd(0, 'h100, 4'h1, "R4");
    wr(0, 'h102, 4'hF, 32'hFFFF_FFFF);
    rd(0, 'h100, 4'hF, "R4");
    rd(0, 'h102, 4'hF, "R4");

    // R5: PHY init flags
    wr(1, 'h010, 4'hF, 32'h0000_00A0);
    wr(1, 'h000, 4'hF, 32'h0000_0005);
    rd(1, 'h010, 4'hF, "R5");
    rd(1, 'h018, 4'hF, "R5");
    rd(1, 'h000, 4'hF, "R5");

    // R6 / R8: row 16, bank 3, page 1 KiB -> base 0x4100_0000
    mem_addr_in = 32'h4100_0ABC;
    wr(0, 'h000, 4'hF, 32'h0000_07F4);
    probe(32'h4100_0ABC, 1'b1, 32'h4000_0ABC, "R6");
    probe(32'h4100_0000, 1'b1, 32'h4000_0000, "R8");
    probe(32'h4100_0FFC, 1'b1, 32'h4000_0FFC, "R8");
    probe(32'h4100_1000, 1'b0, 32'h4100_1000, "R8");
    probe(32'h40FF_FFFC, 1'b0, 32'h40FF_FFFC, "R8");
    rd(0, 'h000, 4'hF, "R2");

    // R7: other offsets leave mirror alone
    wr(0, 'h004, 4'hF, 32'h0000_00A0);
    wr(1, 'h000, 4'hF, 32'h0000_00A0);
    probe(32'h4100_0040, 1'b1, 32'h4000_0040, "R7");

    // R6: row 16, bank 2, page 8 B -> base 0x4001_0000
    wr(0, 'h000, 4'hF, 32'h0000_00F0);
    probe(32'h4001_0123, 1'b1, 32'h4000_0123, "R6");
    probe(32'h4100_0040, 1'b0, 32'h4100_0040, "R6");

    // R6: offset 2^32 wraps onto the base
    wr(0, 'h000, 4'hF, 32'h0000_0FF4);
    probe(32'h4000_0123, 1'b1, 32'h4000_0123, "R6");

    // R7: matching row count turns the mirror off
    mem_addr_in = 32'h4000_0200;
    wr(0, 'h000, 4'hF, 32'h0000_00A0);
    probe(32'h4000_0200, 1'b0, 32'h4000_0200, "R7");
    probe(32'h4010_0000, 1'b0, 32'h4010_0000, "R7");

    // R7: partial geometry write ignored, re-enable, then a misaligned one ignored
    wr(0, 'h000, 4'h7, 32'h0000_00F0);
    probe(32'h4001_0000, 1'b0, 32'h4001_0000, "R7");
    wr(0, 'h000, 4'hF, 32'h0000_00F0);
    wr(0, 'h001, 4'hF, 32'h0000_00A0);
    probe(32'h4001_0004, 1'b1, 32'h4000_0004, "R7");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog expired: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule